// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer that sits between a write clock domain and an unrelated read clock domain. It stores 18-bit words in a dual-port array of 2^ADDR_W entries. A word is written when the active-low write enable is sampled low at a write-clock edge. Words come out in the order they were written.

The output timing is fixed while master reset is held low. In standard mode a word stays in the array until the reader requests it. In fall-through mode the oldest word is moved to the output register without any request, and the two status pins become a valid/ready pair. That pair lets several of these FIFOs be chained output-to-input with no extra logic. The status pins are active high in both modes:

| Pin | Standard mode | Fall-through mode |
|---|---|---|
| `rstat_o` | FIFO is empty | A word is valid on `dout_o` |
| `wstat_o` | FIFO is full | The FIFO can accept a word |

Partial reset empties the FIFO but keeps the chosen mode. Retransmit rewinds the read side to the first array location so that data can be read again.

Top module: `dual_mode_fifo`

## Requirements
- R1: After master reset the FIFO is empty and `dout_o` is zero.
  - In standard mode (`mode_i`=0 at reset), `rstat_o`=1 and `wstat_o`=0.
  - In fall-through mode (`mode_i`=1 at reset), `rstat_o`=0 and `wstat_o`=1.
- R2: In standard mode a stored word reaches `dout_o` only through a read, which is `ren_ni` low at a rising `rclk_i` edge. Each read presents the next word in write order. Without a read, `dout_o` keeps its value.
- R3: In fall-through mode, a word written into an empty FIFO appears on `dout_o` at the third rising `rclk_i` edge after its write edge, with `rstat_o`=1 and no read. It stays there until `ren_ni` is low at a rising `rclk_i` edge. That edge consumes the word and presents the next word if one is stored.
- R4: The capacity flags depend on the mode.
  - In standard mode, `wstat_o`=1 exactly when 2^ADDR_W words are stored.
  - In fall-through mode, `wstat_o`=0 once the array holds 2^ADDR_W words in addition to the word on the output.
- R5: When `rt_ni` is low at a rising `rclk_i` edge, the read position returns to array location 0. Later reads then return the words again from the first one written after reset. This is valid while at most 2^ADDR_W words have been written since the last reset.
- R6: When `prst_ni` is low, the FIFO empties, the flags return to their reset values for the current mode, and `dout_o` is cleared. The latched timing mode is not changed.
- R7: A write while the FIFO is full is dropped, and a read while it is empty is ignored. Neither one moves a pointer, so later transfers keep their order.
- R8: While `oe_ni` is high, `dout_o` is driven to zero. Status and stored data are not affected, and the held word returns when `oe_ni` goes low.
- R9: `mode_i` is sampled only while `rst_ni` is low. Changing it later has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| prst_ni | input | 1 | Partial reset, asynchronous, active low |
| mode_i | input | 1 | Timing mode sampled during master reset (1 = fall-through) |
| wen_ni | input | 1 | Write enable, active low |
| din_i | input | DATA_W | Write data |
| ren_ni | input | 1 | Read enable, active low |
| rt_ni | input | 1 | Retransmit, active low |
| oe_ni | input | 1 | Output enable, active low |
| dout_o | output | DATA_W | Read data |
| rstat_o | output | 1 | Empty flag (standard) or output valid (fall-through) |
| wstat_o | output | 1 | Full flag (standard) or input ready (fall-through) |

## Verification
The bench targets the following corner cases, and each one catches a specific class of bug:
- **Fall-through latency.** It counts read-clock edges from the write edge to the fall-through output. A synchroniser with a missing or extra stage shows the word one edge early or late.
- **Full boundary.** It fills the FIFO in both modes, writes one extra word, then drains. A full test that is off by one either drops a valid word or overwrites the oldest one, and the drained sequence shows it.
- **Read from empty.** It reads while empty in standard mode. A pointer that moves anyway returns stale or duplicated data on the next read.
- **Retransmit, partial reset and mode change.** It checks that retransmit replays from the first word, and that partial reset in fall-through mode leaves the block in fall-through. It also changes `mode_i` after reset, which catches a design that re-samples the pin.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FT = 1'b1} fifo_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/fifo_gsync.sv
module fifo_gsync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [fifo_pkg::SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(fifo_pkg::SYNC_STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < int'(fifo_pkg::SYNC_STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[fifo_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic            wclk_i,
  input  logic            rst_ni,
  input  logic            wen_ni,
  input  logic [ADDR_W:0] rq2_gray_i,
  output logic [ADDR_W:0] wr_bin_o,
  output logic [ADDR_W:0] wr_gray_o,
  output logic            full_o,
  output logic            we_o
);
  logic [ADDR_W:0] wr_bin_q;
  logic [ADDR_W:0] wr_gray_q;
  logic [ADDR_W:0] wr_bin_nx;

  // full: read pointer one lap behind in Gray space
  assign full_o    = (wr_gray_q == {~rq2_gray_i[ADDR_W:ADDR_W-1], rq2_gray_i[ADDR_W-2:0]});
  assign we_o      = !wen_ni && !full_o;
  assign wr_bin_nx = wr_bin_q + 1'b1;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
    end else if (we_o) begin
      wr_bin_q  <= wr_bin_nx;
      wr_gray_q <= wr_bin_nx ^ (wr_bin_nx >> 1);
    end
  end

  assign wr_bin_o  = wr_bin_q;
  assign wr_gray_o = wr_gray_q;
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              ft_i,
  input  logic              ren_ni,
  input  logic              rt_ni,
  input  logic [ADDR_W:0]   wq2_gray_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W:0]   rd_bin_o,
  output logic [ADDR_W:0]   rd_gray_o,
  output logic              empty_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] dq_o
);
  logic [ADDR_W:0]   rd_bin_q;
  logic [ADDR_W:0]   rd_gray_q;
  logic [ADDR_W:0]   rd_bin_nx;
  logic [DATA_W-1:0] dq_q;
  logic              valid_q;
  logic              ft_load;
  logic              std_load;

  assign empty_o   = (rd_gray_q == wq2_gray_i);
  assign rd_bin_nx = rd_bin_q + 1'b1;
  assign ft_load   = ft_i && !empty_o && (!valid_q || !ren_ni);
  assign std_load  = !ft_i && !empty_o && !ren_ni;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
      dq_q      <= '0;
      valid_q   <= 1'b0;
    end else if (!rt_ni) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
      if (ft_i) valid_q <= 1'b0; // refill from location 0
    end else if (ft_load || std_load) begin
      dq_q      <= rdata_i;
      rd_bin_q  <= rd_bin_nx;
      rd_gray_q <= rd_bin_nx ^ (rd_bin_nx >> 1);
      if (ft_i) valid_q <= 1'b1;
    end else if (ft_i && !ren_ni) begin
      valid_q <= 1'b0;
    end
  end

  assign rd_bin_o  = rd_bin_q;
  assign rd_gray_o = rd_gray_q;
  assign valid_o   = valid_q;
  assign dq_o      = dq_q;
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              mode_i,
  input  logic              wen_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ren_ni,
  input  logic              rt_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] dout_o,
  output logic              rstat_o,
  output logic              wstat_o
);
  import fifo_pkg::*;

  fifo_mode_e        mode_q;
  logic              ft;
  logic              ptr_rst_n;
  logic [ADDR_W:0]   wr_bin, wr_gray, rd_bin, rd_gray, rq2_gray, wq2_gray;
  logic              full, empty, we, valid;
  logic [DATA_W-1:0] rdata, dq;

  // mode follows the pin only while master reset is held
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(mode_i);
    else         mode_q <= mode_q;
  end

  assign ft        = (mode_q == MODE_FT);
  assign ptr_rst_n = rst_ni & prst_ni;

  fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(wr_bin[ADDR_W-1:0]),
    .wdata_i(din_i),
    .raddr_i(rd_bin[ADDR_W-1:0]),
    .rdata_o(rdata)
  );

  fifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .wclk_i    (wclk_i),
    .rst_ni    (ptr_rst_n),
    .wen_ni    (wen_ni),
    .rq2_gray_i(rq2_gray),
    .wr_bin_o  (wr_bin),
    .wr_gray_o (wr_gray),
    .full_o    (full),
    .we_o      (we)
  );

  fifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rclk_i    (rclk_i),
    .rst_ni    (ptr_rst_n),
    .ft_i      (ft),
    .ren_ni    (ren_ni),
    .rt_ni     (rt_ni),
    .wq2_gray_i(wq2_gray),
    .rdata_i   (rdata),
    .rd_bin_o  (rd_bin),
    .rd_gray_o (rd_gray),
    .empty_o   (empty),
    .valid_o   (valid),
    .dq_o      (dq)
  );

  fifo_gsync #(.W(ADDR_W + 1)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(ptr_rst_n),
    .d_i   (wr_gray),
    .q_o   (wq2_gray)
  );

  fifo_gsync #(.W(ADDR_W + 1)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(ptr_rst_n),
    .d_i   (rd_gray),
    .q_o   (rq2_gray)
  );

  assign rstat_o = ft ? valid : empty;
  assign wstat_o = ft ? !full : full;
  assign dout_o  = oe_ni ? '0 : dq;
endmodule

module fifo_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 8
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              prst_ni,
  input logic              wen_ni,
  input logic              ren_ni,
  input logic              rt_ni,
  input logic              rstat_o,
  input logic              ft,
  input logic              full,
  input logic              empty,
  input logic [ADDR_W:0]   wr_bin,
  input logic [ADDR_W:0]   rd_bin,
  input logic [DATA_W-1:0] dq
);
  // R7
  wr_hold_when_full_chk: assert property (@(posedge wclk_i) disable iff (!(rst_ni && prst_ni))
    (full && !wen_ni) |=> (wr_bin == $past(wr_bin)));

  // R7
  rd_hold_when_empty_chk: assert property (@(posedge rclk_i) disable iff (!(rst_ni && prst_ni))
    (empty && rt_ni) |=> $stable(rd_bin));

  // R3
  ft_word_hold_chk: assert property (@(posedge rclk_i) disable iff (!(rst_ni && prst_ni))
    (ft && rstat_o && ren_ni && rt_ni) |=> (rstat_o && $stable(dq)));

  // R2
  std_out_hold_chk: assert property (@(posedge rclk_i) disable iff (!(rst_ni && prst_ni))
    (!ft && ren_ni) |=> $stable(dq));

  // R5
  rt_rewind_chk: assert property (@(posedge rclk_i) disable iff (!(rst_ni && prst_ni))
    !rt_ni |=> (rd_bin == '0));
endmodule

bind dual_mode_fifo fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk_i (wclk_i),
  .rclk_i (rclk_i),
  .rst_ni (rst_ni),
  .prst_ni(prst_ni),
  .wen_ni (wen_ni),
  .ren_ni (ren_ni),
  .rt_ni  (rt_ni),
  .rstat_o(rstat_o),
  .ft     (ft),
  .full   (full),
  .empty  (empty),
  .wr_bin (wr_bin),
  .rd_bin (rd_bin),
  .dq     (dq)
);

// File: tb/sim_dual_mode_fifo.sv
`timescale 1ns/1ps
module sim_dual_mode_fifo;
  localparam int DW = 18;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0;
  logic rst_n, prst_n, mode, wen_n, ren_n, rt_n, oe_n;
  logic [DW-1:0] din, dout;
  logic rstat, wstat;
  int n_chk = 0, n_fail = 0;

  always #5 wclk = ~wclk;
  initial begin #2.5; forever #5 rclk = ~rclk; end

  dual_mode_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prst_ni(prst_n), .mode_i(mode),
    .wen_ni(wen_n), .din_i(din), .ren_ni(ren_n), .rt_ni(rt_n), .oe_ni(oe_n),
    .dout_o(dout), .rstat_o(rstat), .wstat_o(wstat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_r(input int n); repeat (n) @(negedge rclk); endtask
  task automatic wait_w(input int n); repeat (n) @(negedge wclk); endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk); wen_n = 0; din = d;
    @(negedge wclk); wen_n = 1;
  endtask

  task automatic rd_std(input logic [DW-1:0] exp, input string tag);
    @(negedge rclk); ren_n = 0;
    @(negedge rclk); ren_n = 1;
    chk(tag, dout, exp);
  endtask

  task automatic rd_ft(input logic [DW-1:0] exp, input string tag);
    @(negedge rclk);
    chk({tag, " valid"}, rstat, 1);
    chk(tag, dout, exp);
    ren_n = 0;
    @(negedge rclk); ren_n = 1;
  endtask

  task automatic mreset(input logic m);
    rst_n = 0; mode = m;
    wait_w(3);
    rst_n = 1;
    wait_w(2);
  endtask

  task automatic t_reset_std;
    mreset(0);
    chk("R1 empty", rstat, 1);
    chk("R1 full", wstat, 0);
    chk("R1 dout", dout, 0);
  endtask

  task automatic t_std_basic;
    wr(18'h00A01); wr(18'h00A02); wr(18'h00A03);
    wait_r(4);
    chk("R2 no read no data", dout, 0);
    chk("R2 not empty", rstat, 0);
    rd_std(18'h00A01, "R2 rd1");
    rd_std(18'h00A02, "R2 rd2");
    rd_std(18'h00A03, "R2 rd3");
    chk("R2 empty after drain", rstat, 1);
  endtask

  task automatic t_empty_read;
    rd_std(18'h00A03, "R7 read while empty holds");
    wr(18'h2B0B0);
    wait_r(4);
    rd_std(18'h2B0B0, "R7 next word after empty read");
  endtask

  task automatic t_full_std;
    for (int i = 0; i < DEPTH; i++) wr(18'h0C000 + 18'(i));
    chk("R4 full std", wstat, 1);
    wr(18'h3FFFF);
    chk("R4 still full", wstat, 1);
    wait_r(4);
    for (int i = 0; i < DEPTH; i++) rd_std(18'h0C000 + 18'(i), "R7 order after dropped write");
    chk("R4 empty after full drain", rstat, 1);
    rd_std(18'h0C000 + 18'(DEPTH - 1), "R7 extra write dropped");
    wait_w(4);
    chk("R4 not full after drain", wstat, 0);
  endtask

  task automatic t_oe;
    @(negedge rclk); oe_n = 1; #1;
    chk("R8 dout zero when disabled", dout, 0);
    chk("R8 status unchanged", rstat, 1);
    @(negedge rclk); oe_n = 0; #1;
    chk("R8 held word returns", dout, 18'h0C000 + 18'(DEPTH - 1));
  endtask

  task automatic t_retransmit;
    @(negedge wclk); prst_n = 0;
    @(negedge wclk); prst_n = 1;
    wait_w(2);
    chk("R6 std empty after partial reset", rstat, 1);
    chk("R6 dout cleared", dout, 0);
    for (int i = 0; i < 4; i++) wr(18'h0D000 + 18'(i));
    wait_r(4);
    for (int i = 0; i < 4; i++) rd_std(18'h0D000 + 18'(i), "R5 first pass");
    chk("R5 empty before rewind", rstat, 1);
    @(negedge rclk); rt_n = 0;
    @(negedge rclk); rt_n = 1;
    chk("R5 data after rewind", rstat, 0);
    for (int i = 0; i < 4; i++) rd_std(18'h0D000 + 18'(i), "R5 replay");
  endtask

  task automatic t_ft;
    mreset(1);
    mode = 0; // R9: change after reset must not matter
    chk("R1 ft no valid", rstat, 0);
    chk("R1 ft ready", wstat, 1);
    @(negedge wclk); wen_n = 0; din = 18'h1E000;
    @(negedge wclk); wen_n = 1;       // write edge T; rclk edges T+2.5, T+12.5, T+22.5
    @(posedge rclk); #1;
    chk("R3 not valid at second edge", rstat, 0);
    @(posedge rclk); #1;
    chk("R3 valid at third edge", rstat, 1);
    chk("R3 R9 word fell through", dout, 18'h1E000);
    wait_r(3);
    chk("R3 word held without read", dout, 18'h1E000);
    wr(18'h1E001); wr(18'h1E002);
    wait_r(4);
    rd_ft(18'h1E000, "R3 ft word0");
    rd_ft(18'h1E001, "R3 ft word1");
    rd_ft(18'h1E002, "R3 ft word2");
    chk("R3 no valid after drain", rstat, 0);
  endtask

  task automatic t_ft_full;
    for (int i = 0; i <= DEPTH; i++) wr(18'h0F000 + 18'(i));
    wait_w(6);
    chk("R4 ft not ready when full", wstat, 0);
    wr(18'h3FFFF);
    wait_r(4);
    for (int i = 0; i <= DEPTH; i++) rd_ft(18'h0F000 + 18'(i), "R7 ft order after dropped write");
    chk("R7 ft extra write dropped", rstat, 0);
    wait_w(4);
    chk("R4 ft ready after drain", wstat, 1);
  endtask

  task automatic t_ft_prst;
    wr(18'h01010);
    wait_r(5);
    chk("R6 ft word present", rstat, 1);
    @(negedge wclk); prst_n = 0;
    @(negedge wclk); prst_n = 1;
    wait_w(1);
    chk("R6 ft valid cleared", rstat, 0);
    chk("R6 ft ready", wstat, 1);
    wr(18'h02020);
    wait_r(5);
    chk("R6 mode kept, word fell through", rstat, 1);
    chk("R6 mode kept, data", dout, 18'h02020);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; prst_n = 1; mode = 0; wen_n = 1; ren_n = 1; rt_n = 1; oe_n = 0; din = '0;
    t_reset_std();
    t_std_basic();
    t_empty_read();
    t_full_std();
    t_oe();
    t_retransmit();
    t_ft();
    t_ft_full();
    t_ft_prst();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule